// File: doc/BRIEF.md
# Duplicated Parity-Guarded Associative Search

This block is a search table that tolerates a single upset in its storage. Every written word and every search key gets an even-parity bit added at the top. The extended words are kept in two identical associative arrays. A search compares the extended key against every valid entry of both arrays in parallel. A merge stage then combines the two sets of match lines into one corrected result: a hit flag, an entry index, a match count and the full match vector. A single flipped bit turns a stored word into a value with the wrong parity, and no search key can ever have the wrong parity. So a corrupted entry can only drop out of a match; it can never create a false one. The merge stage therefore trusts whichever copy reports more matches.

Two ways of resolving multiple matches are offered at search time. In priority mode, the result is the union of both copies' match lines, and the index is the highest matching entry number. In count mode, the result is the whole match set of the copy with the larger match count. On a tie the first copy wins. When the copies disagree, a one-cycle error flag is raised. A sticky flag also records which copy came up short. Each copy has its own bit-flip injection port so that upsets can be exercised.

Top module: `dupcam_guard`

## Requirements
- R1: Stored words and search keys are extended as {even parity of the data, data}, with the parity at bit W. After any single bit flip in a stored entry, including its parity bit, that entry matches no search key in its copy.
- R2: When both copies report identical match lines, the result has hit=1, the common lines, their population count and the highest set index, and err=0.
- R3: When exactly one copy has any match, the result is a hit that carries that copy's lines, count and index.
- R4: When neither copy matches, the result has res_hit=0, res_idx=0, res_cnt=0 and res_lines=0.
- R5: In priority mode (mode_unres=0), res_lines is the OR of both copies' lines, res_idx is the highest set entry number, and res_cnt is the population count of that union.
- R6: In count mode (mode_unres=1), the result is taken from the copy with the larger match count; on equal counts it is taken from copy A.
- R7: err is 1 in the result cycle exactly when the two copies' match lines differ. err is 0 in any cycle without a result.
- R8: fault_a (fault_b) becomes 1 after a search in which copy A (B) had strictly fewer matches than the other copy. It stays 1 until reset.
- R9: A search issued with srch_en at one rising edge is reported with res_vld=1 after that edge, and res_vld is 0 after an edge with no search.
- R10: A write sets the entry in both copies to the parity-extended data and marks it valid. Reset invalidates every entry and clears the fault flags.
- R11: A flip request alters only the selected copy; the other copy keeps matching the original word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write the word into both copies |
| wr_idx | input | IDXW | Entry written |
| wr_data | input | W | Word written (without parity) |
| srch_en | input | 1 | Issue a search |
| srch_data | input | W | Search key (without parity) |
| mode_unres | input | 1 | 0: priority merge, 1: count merge |
| flip_a | input | 1 | Invert one stored bit in copy A |
| flip_b | input | 1 | Invert one stored bit in copy B |
| flip_idx | input | IDXW | Entry to corrupt |
| flip_bit | input | BW | Bit position to invert (W is the parity bit) |
| res_vld | output | 1 | Result valid this cycle |
| res_hit | output | 1 | Corrected hit |
| res_idx | output | IDXW | Highest matching entry of the result |
| res_cnt | output | CNTW | Number of matching entries in the result |
| res_lines | output | ENTRIES | Match vector of the result |
| err | output | 1 | The copies disagreed on this result |
| fault_a | output | 1 | Sticky: copy A lost a match |
| fault_b | output | 1 | Sticky: copy B lost a match |

## Verification
The bench sweeps every search key in both merge modes against a table that holds duplicated words. It repeats the sweep after upsets in data bits and in the parity bit of each copy. If the parity extension were missing, a flipped entry would produce a false hit on the corrupted value. If the merge took a fixed copy instead of the one with more matches, a lost match would show up as a miss or as a wrong index. The test also provokes equal counts with different lines by upsetting both copies. A tie rule that does not favour copy A then returns the wrong vector, while priority mode must still report the union. A reset in the middle of the run checks that the fault flags are sticky and clear only on reset.

// File: rtl/dupcam_guard.sv
module dupcam_guard #(
  parameter int W = 4,
  parameter int ENTRIES = 8,
  localparam int IDXW = $clog2(ENTRIES),
  localparam int CNTW = $clog2(ENTRIES + 1),
  localparam int XW = W + 1,
  localparam int BW = $clog2(XW)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [IDXW-1:0]     wr_idx,
  input  logic [W-1:0]        wr_data,
  input  logic                srch_en,
  input  logic [W-1:0]        srch_data,
  input  logic                mode_unres,
  input  logic                flip_a,
  input  logic                flip_b,
  input  logic [IDXW-1:0]     flip_idx,
  input  logic [BW-1:0]       flip_bit,
  output logic                res_vld,
  output logic                res_hit,
  output logic [IDXW-1:0]     res_idx,
  output logic [CNTW-1:0]     res_cnt,
  output logic [ENTRIES-1:0]  res_lines,
  output logic                err,
  output logic                fault_a,
  output logic                fault_b
);

  logic [XW-1:0]      mem_a [ENTRIES];
  logic [XW-1:0]      mem_b [ENTRIES];
  logic [ENTRIES-1:0] used;
  logic [ENTRIES-1:0] ml_a, ml_b, pick;
  logic [CNTW-1:0]    cnt_a, cnt_b;
  logic [XW-1:0]      key;

  function automatic logic [CNTW-1:0] popc(input logic [ENTRIES-1:0] v);
    logic [CNTW-1:0] n;
    n = '0;
    for (int i = 0; i < ENTRIES; i++) n = n + CNTW'(v[i]);
    return n;
  endfunction

  function automatic logic [IDXW-1:0] top_idx(input logic [ENTRIES-1:0] v);
    logic [IDXW-1:0] n;
    n = '0;
    for (int i = 0; i < ENTRIES; i++) if (v[i]) n = IDXW'(i);
    return n;
  endfunction

  assign key = {^srch_data, srch_data};

  for (genvar e = 0; e < ENTRIES; e++) begin : g_match
    assign ml_a[e] = used[e] && (mem_a[e] == key);
    assign ml_b[e] = used[e] && (mem_b[e] == key);
  end

  assign cnt_a = popc(ml_a);
  assign cnt_b = popc(ml_b);
  assign pick  = !mode_unres ? (ml_a | ml_b) : (cnt_b > cnt_a) ? ml_b : ml_a;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      used <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        mem_a[i] <= '0;
        mem_b[i] <= '0;
      end
    end else begin
      if (wr_en) begin
        used[wr_idx]  <= 1'b1;
        mem_a[wr_idx] <= {^wr_data, wr_data};
        mem_b[wr_idx] <= {^wr_data, wr_data};
      end
      if (flip_a) mem_a[flip_idx][flip_bit] <= ~mem_a[flip_idx][flip_bit];
      if (flip_b) mem_b[flip_idx][flip_bit] <= ~mem_b[flip_idx][flip_bit];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_vld   <= 1'b0;
      res_hit   <= 1'b0;
      res_idx   <= '0;
      res_cnt   <= '0;
      res_lines <= '0;
      err       <= 1'b0;
      fault_a   <= 1'b0;
      fault_b   <= 1'b0;
    end else begin
      res_vld <= srch_en;
      err     <= srch_en && (ml_a != ml_b);
      if (srch_en) begin
        res_hit   <= |pick;
        res_idx   <= top_idx(pick);
        res_cnt   <= popc(pick);
        res_lines <= pick;
        if (cnt_a < cnt_b) fault_a <= 1'b1;
        if (cnt_b < cnt_a) fault_b <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/dupcam_guard_chk.sv
module dupcam_guard_chk #(
  parameter int ENTRIES = 8,
  parameter int IDXW = 3,
  parameter int CNTW = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               srch_en,
  input logic               res_vld,
  input logic               res_hit,
  input logic [IDXW-1:0]    res_idx,
  input logic [CNTW-1:0]    res_cnt,
  input logic [ENTRIES-1:0] res_lines,
  input logic               err,
  input logic               fault_a,
  input logic               fault_b
);

  // R9
  issue_to_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srch_en |=> res_vld);

  // R9
  idle_no_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !srch_en |=> !res_vld);

  // R7
  err_only_with_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> res_vld);

  // R8
  fault_a_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_a |=> fault_a);

  // R8
  fault_b_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_b |=> fault_b);

  // R4
  miss_is_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && !res_hit) |-> (res_cnt == '0 && res_idx == '0 && res_lines == '0));

  // R2
  count_matches_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |-> (res_cnt == CNTW'($countones(res_lines)) && res_hit == (res_lines != '0)));

  // R5
  index_is_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && res_hit) |-> (res_lines[res_idx] && (res_lines >> res_idx) == ENTRIES'(1)));

endmodule

bind dupcam_guard dupcam_guard_chk #(.ENTRIES(ENTRIES), .IDXW(IDXW), .CNTW(CNTW)) u_chk (
  .clk(clk), .rst_n(rst_n), .srch_en(srch_en), .res_vld(res_vld), .res_hit(res_hit),
  .res_idx(res_idx), .res_cnt(res_cnt), .res_lines(res_lines), .err(err),
  .fault_a(fault_a), .fault_b(fault_b)
);

// File: tb/sim_dupcam_guard.sv
module sim_dupcam_guard;
  localparam int W = 4;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, srch_en = 1'b0, mode_unres = 1'b0, flip_a = 1'b0, flip_b = 1'b0;
  logic [2:0] wr_idx = '0, flip_idx = '0, flip_bit = '0;
  logic [W-1:0] wr_data = '0, srch_data = '0;
  logic res_vld, res_hit, err, fault_a, fault_b;
  logic [2:0] res_idx;
  logic [3:0] res_cnt;
  logic [N-1:0] res_lines;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [W:0] m_a [N];
  logic [W:0] m_b [N];
  logic [N-1:0] m_used = '0;
  bit mfa = 0, mfb = 0;

  always #2 clk = ~clk;

  dupcam_guard u0 (.*);

  task automatic check(string tag, logic [19:0] got, logic [19:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h expected=%h", tag, got, exp);
    end
  endtask

  function automatic logic [19:0] now_out();
    return {res_vld, res_hit, res_idx, res_cnt, res_lines, err, fault_a, fault_b};
  endfunction

  function automatic int cnt_of(logic [N-1:0] v);
    int n = 0;
    for (int i = 0; i < N; i++) n += v[i];
    return n;
  endfunction

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    m_used = '0; mfa = 0; mfb = 0;
    for (int i = 0; i < N; i++) begin m_a[i] = '0; m_b[i] = '0; end
  endtask

  task automatic wr(int e, logic [W-1:0] d);
    @(negedge clk) wr_en = 1'b1; wr_idx = 3'(e); wr_data = d;
    @(negedge clk) wr_en = 1'b0;
    m_used[e] = 1'b1; m_a[e] = {^d, d}; m_b[e] = {^d, d};
  endtask

  task automatic flip(bit to_b, int e, int b);
    @(negedge clk) flip_a = !to_b; flip_b = to_b; flip_idx = 3'(e); flip_bit = 3'(b);
    @(negedge clk) flip_a = 1'b0; flip_b = 1'b0;
    if (to_b) m_b[e][b] = ~m_b[e][b]; else m_a[e][b] = ~m_a[e][b];
  endtask

  task automatic search(string tag_in, logic [W-1:0] s, bit mode);
    logic [N-1:0] va, vb, ln;
    logic [W:0] k;
    logic [2:0] ix;
    string tag;
    k = {^s, s};
    for (int i = 0; i < N; i++) begin
      va[i] = m_used[i] && m_a[i] == k;
      vb[i] = m_used[i] && m_b[i] == k;
    end
    ln = !mode ? (va | vb) : (cnt_of(vb) > cnt_of(va)) ? vb : va;
    ix = '0;
    for (int i = 0; i < N; i++) if (ln[i]) ix = 3'(i);
    if (cnt_of(va) < cnt_of(vb)) mfa = 1;
    if (cnt_of(vb) < cnt_of(va)) mfb = 1;
    tag = tag_in;
    if (tag == "") begin
      if (ln == '0) tag = "R4";
      else if ((va == '0) != (vb == '0)) tag = "R3";
      else if (va != vb) tag = mode ? "R6" : "R5";
      else tag = "R2";
    end
    @(negedge clk) srch_en = 1'b1; srch_data = s; mode_unres = mode;
    @(negedge clk) srch_en = 1'b0;
    check(tag, now_out(), {1'b1, ln != '0, ix, 4'(cnt_of(ln)), ln, va != vb, mfa, mfb});
  endtask

  task automatic sweep();
    for (int m = 0; m < 2; m++)
      for (int s = 0; s < 16; s++) search("", 4'(s), m[0]);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    do_reset();
    // R10: reset state
    check("R10", now_out(), 20'h0);
    search("R10", 4'h0, 1'b0);
    // R9 / R7: no search issued -> no result, no err
    @(negedge clk);
    check("R9", {res_vld, err}, {1'b0, 1'b0});
    check("R7", {19'h0, err}, 20'h0);
    for (int e = 0; e < N; e++) wr(e, 4'(e % 5));
    sweep();
    // R1: data bit 0 of entry 5 (word 0) in copy A flipped -> no false hit on 1
    flip(1'b0, 5, 0);
    search("R1", 4'h1, 1'b0);
    // R11: copy B still matches original word at entry 5
    search("R11", 4'h0, 1'b1);
    check("R8", {18'h0, fault_a, fault_b}, {18'h0, 2'b10});
    flip(1'b0, 3, 2);
    search("R3", 4'h3, 1'b0);
    search("R3", 4'h3, 1'b1);
    // R1: parity bit of entry 7 (word 2) in copy B
    flip(1'b1, 7, 4);
    search("R1", 4'h2, 1'b0);
    search("R6", 4'h2, 1'b1);
    check("R8", {18'h0, fault_a, fault_b}, {18'h0, 2'b11});
    sweep();
    // both copies lose a different copy of word 0: tie in count mode
    flip(1'b1, 0, 1);
    search("R6", 4'h0, 1'b1);
    search("R5", 4'h0, 1'b0);
    @(negedge clk);
    check("R7", {19'h0, err}, 20'h0);
    check("R8", {18'h0, fault_a, fault_b}, {18'h0, 2'b11});
    do_reset();
    check("R8", now_out(), 20'h0);
    search("R10", 4'h0, 1'b1);
    for (int e = 0; e < N; e++) wr(e, 4'(15 - e));
    sweep();
    done = 1;
  end

  initial begin
    for (int t = 0; t < 100000; t++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog got=hung expected=finished");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule